// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the combinational arithmetic and logic unit of a small 8-bit accumulator processor. On each evaluation it takes a 4-bit operation code and four bytes: the accumulator, the X index register, the memory operand and the current status byte. From these it produces an 8-bit result, a 2-bit hint that says which register or location should take the result, and a new status byte.

The operations are:

- add with carry and subtract with borrow;
- compares against A or X;
- AND, OR and XOR;
- a bit test;
- shifts and rotates, increment and decrement of the operand;
- an operation that ANDs A with X, subtracts the operand and sends the result to X.

The block only updates the negative, overflow, zero and carry bits. Every other status bit passes through unchanged. Decimal mode is never applied. The surrounding datapath decodes instructions, holds the registers and uses the destination hint to choose where the result is written.

Top module: `alu8_core`

## Requirements
- R1: Op code 0 (add) gives res_o = low byte of A + M + C_in and sets C (status bit 0) to bit 8 of that 9-bit sum. The destination is A (code 1).
- R2: For add, V (status bit 6) is 1 exactly when A and M have equal sign bits and the sign of res_o differs from the sign of A.
- R3: Op code 1 (subtract) gives res_o = low byte of A − M − (1 − C_in). C is 1 when no borrow occurs. V is 1 when A and M differ in sign and the sign of res_o differs from the sign of A. The destination is A.
- R4: Op codes 2 (compare A) and 3 (compare X) give res_o = low byte of reg − M. C is 1 when reg ≥ M unsigned. V is unchanged and the destination is none (code 0).
- R5: Op codes 4 (AND), 5 (OR) and 6 (XOR) combine A and M bitwise, send the result to A and leave C and V unchanged.
- R6: Op code 7 (bit test) gives res_o = A AND M, with destination none. Z (bit 1) is set when that value is zero, N (bit 7) takes M bit 7 and V takes M bit 6. C is unchanged.
- R7: Op codes 8 (shift left) and 9 (shift right) shift M by one place and fill with zero. The bit shifted out goes to C. A right shift always gives N = 0. The destination is memory (code 3).
- R8: Op codes 10 (rotate left) and 11 (rotate right) shift M by one place. The old C enters at bit 0 for a left rotate and at bit 7 for a right rotate. The bit shifted out becomes C. The destination is memory.
- R9: Op codes 12 (increment) and 13 (decrement) give M ± 1 modulo 256, leave C and V unchanged and send the result to memory.
- R10: Op code 14 gives res_o = low byte of (A AND X) − M, with no borrow-in from C. It sets C, N and Z as a compare does, leaves V unchanged and sends the result to X (code 2).
- R11: For op codes 0 to 14, Z is 1 exactly when res_o is zero. Except for the bit test, N equals res_o bit 7. Status bits 2 to 5 always pass through unchanged.
- R12: The decimal flag (status bit 3) has no effect: add and subtract always use binary arithmetic.
- R13: Op code 15 is a no-operation. It gives res_o = M, destination none and a status byte equal to the input status byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Accumulator value |
| x_i | input | 8 | X index register value |
| m_i | input | 8 | Memory or immediate operand |
| p_i | input | 8 | Incoming status byte |
| res_o | output | 8 | Operation result |
| dest_o | output | 2 | Destination hint: 0 none, 1 A, 2 X, 3 memory |
| p_o | output | 8 | Updated status byte |

## Verification
Add and subtract are swept over a grid of operand pairs with both carry-in values and compared against an integer model. This separates carry from overflow, because pairs with equal signs and pairs with opposite signs both appear, and results cross both 0x00 and 0x80. Directed vectors give each shift and rotate an operand whose outgoing bit differs from the incoming carry, so any mix-up between the old and new C shows. Compare and the AND-then-subtract are tried with an operand below, equal to and above the register value. They are also given a carry-in that should be ignored. The decimal flag and the unused status bits are held set in several vectors to show they pass through.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int unsigned FLAG_C = 0;
  localparam int unsigned FLAG_Z = 1;
  localparam int unsigned FLAG_V = 6;
  localparam int unsigned FLAG_N = 7;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMPA = 4'd2,
    OP_CMPX = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_BIT  = 4'd7,
    OP_ASL  = 4'd8,
    OP_LSR  = 4'd9,
    OP_ROL  = 4'd10,
    OP_ROR  = 4'd11,
    OP_INC  = 4'd12,
    OP_DEC  = 4'd13,
    OP_SBX  = 4'd14,
    OP_NOP  = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_A    = 2'd1,
    DST_X    = 2'd2,
    DST_MEM  = 2'd3
  } alu_dst_e;

  typedef enum logic [2:0] {
    SH_ASL = 3'd0,
    SH_LSR = 3'd1,
    SH_ROL = 3'd2,
    SH_ROR = 3'd3,
    SH_INC = 3'd4,
    SH_DEC = 3'd5
  } shf_mode_e;

  typedef enum logic [1:0] {
    BW_AND = 2'd0,
    BW_OR  = 2'd1,
    BW_XOR = 2'd2
  } bw_sel_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] lhs_i,
  input  logic [DW-1:0] rhs_i,
  input  logic          inv_i,
  input  logic          cin_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o,
  output logic          ovf_o
);
  localparam int unsigned MSB = DW - 1;

  logic [DW-1:0] rhs_eff;
  logic [DW:0]   total;

  always_comb begin
    rhs_eff = inv_i ? ~rhs_i : rhs_i;
    total   = {1'b0, lhs_i} + {1'b0, rhs_eff} + {{DW{1'b0}}, cin_i};
    sum_o   = total[DW-1:0];
    cout_o  = total[DW];
    ovf_o   = (lhs_i[MSB] == rhs_eff[MSB]) && (total[MSB] != lhs_i[MSB]);
  end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  bw_sel_e       sel_i,
  output logic [DW-1:0] out_o
);
  always_comb begin
    unique case (sel_i)
      BW_OR:   out_o = a_i | b_i;
      BW_XOR:  out_o = a_i ^ b_i;
      default: out_o = a_i & b_i;
    endcase
  end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] val_i,
  input  logic          cin_i,
  input  shf_mode_e     mode_i,
  output logic [DW-1:0] out_o,
  output logic          cout_o
);
  localparam int unsigned MSB = DW - 1;

  always_comb begin
    out_o  = val_i;
    cout_o = cin_i;
    unique case (mode_i)
      SH_ASL: begin out_o = {val_i[MSB-1:0], 1'b0};  cout_o = val_i[MSB]; end
      SH_LSR: begin out_o = {1'b0, val_i[MSB:1]};    cout_o = val_i[0];   end
      SH_ROL: begin out_o = {val_i[MSB-1:0], cin_i}; cout_o = val_i[MSB]; end
      SH_ROR: begin out_o = {cin_i, val_i[MSB:1]};   cout_o = val_i[0];   end
      SH_INC: out_o = val_i + {{(DW-1){1'b0}}, 1'b1};
      SH_DEC: out_o = val_i - {{(DW-1){1'b0}}, 1'b1};
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] m_i,
  input  logic [7:0]    p_i,
  output logic [DW-1:0] res_o,
  output logic [1:0]    dest_o,
  output logic [7:0]    p_o
);
  localparam int unsigned MSB = DW - 1;

  alu_op_e       op;
  logic [DW-1:0] as_lhs;
  logic          as_inv;
  logic          as_cin;
  logic [DW-1:0] as_sum;
  logic          as_cout;
  logic          as_ovf;
  bw_sel_e       bw_sel;
  logic [DW-1:0] bw_out;
  shf_mode_e     sh_mode;
  logic [DW-1:0] sh_out;
  logic          sh_cout;
  logic          c_nx, v_nx, z_nx, n_nx;
  alu_dst_e      dst_nx;

  assign op = alu_op_e'(op_i);

  // operand steering for the shared adder, bitwise unit and shifter
  always_comb begin
    as_lhs  = a_i;
    as_inv  = 1'b1;
    as_cin  = 1'b1;
    bw_sel  = BW_AND;
    sh_mode = SH_ASL;
    unique case (op)
      OP_ADD:  begin as_inv = 1'b0; as_cin = p_i[FLAG_C]; end
      OP_SUB:  as_cin = p_i[FLAG_C];
      OP_CMPX: as_lhs = x_i;
      OP_SBX:  as_lhs = a_i & x_i;
      OP_OR:   bw_sel = BW_OR;
      OP_XOR:  bw_sel = BW_XOR;
      OP_LSR:  sh_mode = SH_LSR;
      OP_ROL:  sh_mode = SH_ROL;
      OP_ROR:  sh_mode = SH_ROR;
      OP_INC:  sh_mode = SH_INC;
      OP_DEC:  sh_mode = SH_DEC;
      default: ;
    endcase
  end

  alu8_addsub #(.DW(DW)) addsub_i (
    .lhs_i(as_lhs), .rhs_i(m_i), .inv_i(as_inv), .cin_i(as_cin),
    .sum_o(as_sum), .cout_o(as_cout), .ovf_o(as_ovf)
  );

  alu8_bitwise #(.DW(DW)) bitwise_i (
    .a_i(a_i), .b_i(m_i), .sel_i(bw_sel), .out_o(bw_out)
  );

  alu8_shifter #(.DW(DW)) shifter_i (
    .val_i(m_i), .cin_i(p_i[FLAG_C]), .mode_i(sh_mode),
    .out_o(sh_out), .cout_o(sh_cout)
  );

  // result selection and flag assembly
  always_comb begin
    res_o  = m_i;
    dst_nx = DST_NONE;
    c_nx   = p_i[FLAG_C];
    v_nx   = p_i[FLAG_V];
    unique case (op)
      OP_ADD, OP_SUB: begin
        res_o = as_sum; dst_nx = DST_A; c_nx = as_cout; v_nx = as_ovf;
      end
      OP_CMPA, OP_CMPX: begin
        res_o = as_sum; c_nx = as_cout;
      end
      OP_SBX: begin
        res_o = as_sum; dst_nx = DST_X; c_nx = as_cout;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_o = bw_out; dst_nx = DST_A;
      end
      OP_BIT: begin
        res_o = bw_out; v_nx = m_i[MSB-1];
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        res_o = sh_out; dst_nx = DST_MEM; c_nx = sh_cout;
      end
      OP_INC, OP_DEC: begin
        res_o = sh_out; dst_nx = DST_MEM;
      end
      default: ;
    endcase
    if (op == OP_NOP) begin
      z_nx = p_i[FLAG_Z];
      n_nx = p_i[FLAG_N];
    end else begin
      z_nx = (res_o == '0);
      n_nx = (op == OP_BIT) ? m_i[MSB] : res_o[MSB];
    end
    dest_o = dst_nx;
    p_o    = p_i;
    p_o[FLAG_C] = c_nx;
    p_o[FLAG_Z] = z_nx;
    p_o[FLAG_V] = v_nx;
    p_o[FLAG_N] = n_nx;
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic [3:0]    op_i,
  input logic [DW-1:0] m_i,
  input logic [7:0]    p_i,
  input logic [DW-1:0] res_o,
  input logic [1:0]    dest_o,
  input logic [7:0]    p_o
);
  always_comb begin
    if (!$isunknown({op_i, m_i, p_i, res_o, dest_o, p_o})) begin
      // R11
      mid_bits_pass_chk: assert (p_o[5:2] == p_i[5:2])
        else $error("status bits 2..5 altered");
      // R11
      zero_flag_chk: assert ((op_i == OP_NOP) || (p_o[FLAG_Z] == (res_o == '0)))
        else $error("Z disagrees with result");
      // R6
      bit_copy_chk: assert ((op_i != OP_BIT) ||
                            (p_o[FLAG_N] == m_i[DW-1] && p_o[FLAG_V] == m_i[DW-2]))
        else $error("bit test N/V not copied from operand");
      // R7
      lsr_neg_chk: assert ((op_i != OP_LSR) || (p_o[FLAG_N] == 1'b0))
        else $error("right shift left N set");
      // R9
      incdec_keep_chk: assert (!(op_i == OP_INC || op_i == OP_DEC) ||
                               (p_o[FLAG_C] == p_i[FLAG_C] && p_o[FLAG_V] == p_i[FLAG_V]))
        else $error("inc/dec touched C or V");
      // R4
      cmp_dest_chk: assert (!(op_i == OP_CMPA || op_i == OP_CMPX) ||
                            (dest_o == DST_NONE && p_o[FLAG_V] == p_i[FLAG_V]))
        else $error("compare wrote a destination or V");
      // R13
      nop_chk: assert ((op_i != OP_NOP) || (p_o == p_i && res_o == m_i))
        else $error("no-op changed status or result");
    end
  end
endmodule

bind alu8_core alu8_core_chk #(.DW(DW)) chk_i (
  .op_i(op_i), .m_i(m_i), .p_i(p_i),
  .res_o(res_o), .dest_o(dest_o), .p_o(p_o)
);

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] a;
    logic [7:0] x;
    logic [7:0] m;
    logic [7:0] p;
    logic [7:0] res;
    logic [1:0] dst;
    logic [7:0] po;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [0:NV-1] = '{
    '{4'd0,  8'h50, 8'h00, 8'h50, 8'h00, 8'hA0, 2'd1, 8'hC0, 8'd2},  // R2 pos+pos overflow
    '{4'd0,  8'hFF, 8'h00, 8'h01, 8'h01, 8'h01, 2'd1, 8'h01, 8'd1},  // R1 carry out
    '{4'd0,  8'h80, 8'h00, 8'h80, 8'h04, 8'h00, 2'd1, 8'h47, 8'd2},  // R2 neg+neg overflow, zero
    '{4'd1,  8'h50, 8'h00, 8'hB0, 8'h01, 8'hA0, 2'd1, 8'hC0, 8'd3},  // R3 borrow and V
    '{4'd1,  8'h05, 8'h00, 8'h03, 8'h00, 8'h01, 2'd1, 8'h01, 8'd3},  // R3 borrow-in
    '{4'd2,  8'h40, 8'h00, 8'h40, 8'h40, 8'h00, 2'd0, 8'h43, 8'd4},  // R4 equal, V kept
    '{4'd3,  8'h99, 8'h10, 8'h20, 8'h01, 8'hF0, 2'd0, 8'h80, 8'd4},  // R4 X below M
    '{4'd3,  8'h00, 8'h30, 8'h20, 8'h00, 8'h10, 2'd0, 8'h01, 8'd4},  // R4 X above M
    '{4'd4,  8'hF0, 8'h00, 8'h0F, 8'h81, 8'h00, 2'd1, 8'h03, 8'd5},  // R5 AND zero
    '{4'd5,  8'h80, 8'h00, 8'h01, 8'h42, 8'h81, 2'd1, 8'hC0, 8'd5},  // R5 OR
    '{4'd6,  8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 2'd1, 8'h02, 8'd5},  // R5 XOR
    '{4'd7,  8'h01, 8'h00, 8'hC0, 8'h00, 8'h00, 2'd0, 8'hC2, 8'd6},  // R6 disjoint
    '{4'd7,  8'hFF, 8'h00, 8'h01, 8'hC3, 8'h01, 2'd0, 8'h01, 8'd6},  // R6 overlap, C kept
    '{4'd8,  8'h00, 8'h00, 8'h81, 8'h00, 8'h02, 2'd3, 8'h01, 8'd7},  // R7 shift left
    '{4'd9,  8'h00, 8'h00, 8'h01, 8'h80, 8'h00, 2'd3, 8'h03, 8'd7},  // R7 shift right
    '{4'd10, 8'h00, 8'h00, 8'h40, 8'h01, 8'h81, 2'd3, 8'h80, 8'd8},  // R8 rotate left
    '{4'd11, 8'h00, 8'h00, 8'h01, 8'h01, 8'h80, 2'd3, 8'h81, 8'd8},  // R8 rotate right
    '{4'd12, 8'h00, 8'h00, 8'hFF, 8'h41, 8'h00, 2'd3, 8'h43, 8'd9},  // R9 increment wrap
    '{4'd13, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 2'd3, 8'h80, 8'd9},  // R9 decrement wrap
    '{4'd14, 8'hF3, 8'h3F, 8'h02, 8'h00, 8'h31, 2'd2, 8'h01, 8'd10}, // R10 no borrow-in
    '{4'd14, 8'h0F, 8'h01, 8'h05, 8'h01, 8'hFC, 2'd2, 8'h80, 8'd10}, // R10 borrow
    '{4'd0,  8'h09, 8'h00, 8'h01, 8'h08, 8'h0A, 2'd1, 8'h08, 8'd12}, // R12 decimal ignored
    '{4'd15, 8'h12, 8'h00, 8'h34, 8'hA5, 8'h34, 2'd0, 8'hA5, 8'd13}  // R13 no-op
  };

  logic       clk;
  logic [3:0] op;
  logic [7:0] a, x, m, p;
  logic [7:0] res;
  logic [1:0] dest;
  logic [7:0] po;
  int total_cnt = 0;
  int bad_cnt   = 0;

  alu8_core dut_i (
    .op_i(op), .a_i(a), .x_i(x), .m_i(m), .p_i(p),
    .res_o(res), .dest_o(dest), .p_o(po)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    bad_cnt++;
    total_cnt++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total_cnt, bad_cnt);
    $finish;
  end

  task automatic drive(input logic [3:0] o, input logic [7:0] av, input logic [7:0] xv,
                       input logic [7:0] mv, input logic [7:0] pv);
    @(posedge clk);
    op = o; a = av; x = xv; m = mv; p = pv;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    total_cnt++;
    if (act !== exp) begin
      bad_cnt++;
      $display("FAIL %s op=%0d a=%h m=%h: actual res/dst/p=%h expected=%h",
               req, op, a, m, act, exp);
    end
  endtask

  initial begin
    op = 4'd15; a = 8'h00; x = 8'h00; m = 8'h00; p = 8'h00;
    @(negedge clk);
    // R13 initial no-op state: result follows M, status unchanged
    check("R13", {res, dest, po}, {8'h00, 2'd0, 8'h00});

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].a, VECS[i].x, VECS[i].m, VECS[i].p);
      check($sformatf("R%0d", VECS[i].req), {res, dest, po},
            {VECS[i].res, VECS[i].dst, VECS[i].po});
    end

    // R1 R2 R3 R11: add and subtract sweep against an integer model
    for (int ai = 0; ai < 256; ai += 17) begin
      for (int mi = 0; mi < 256; mi += 23) begin
        for (int ci = 0; ci < 2; ci++) begin
          for (int sub = 0; sub < 2; sub++) begin
            int s;
            logic [7:0] r, pe;
            logic cf, vf;
            if (sub == 0) begin
              s  = ai + mi + ci;
              r  = s[7:0];
              cf = (s > 255);
              vf = (((ai ^ mi) & 8'h80) == 0) && (((ai ^ r) & 8'h80) != 0);
            end else begin
              s  = ai - mi - (1 - ci);
              r  = s[7:0];
              cf = (s >= 0);
              vf = (((ai ^ mi) & 8'h80) != 0) && (((ai ^ r) & 8'h80) != 0);
            end
            pe = {r[7], vf, 4'b1010, (r == 8'h00), cf};
            drive(sub[3:0], ai[7:0], 8'h5A, mi[7:0], {6'b001010, 1'b0, ci[0]});
            check(sub == 0 ? "R1/R2" : "R3", {res, dest, po}, {r, 2'd1, pe});
          end
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total_cnt, bad_cnt);
    $finish;
  end
endmodule